// File: doc/BRIEF.md
# Transmit Message Length Counter

This block counts down the bytes still owed to an outgoing serial message and tells the framing logic when to close that message without software help. Software can set the count directly. It can also write a reload register whose value is copied into the count each time a new message starts. Every counted write into the transmit FIFO lowers the count by one. The close request waits until the byte that brought the count to zero has left the shift register, not just until it was written.

Several bytes may be queued in the FIFO when the count reaches zero. To handle this, the block keeps its own tally of bytes written but not yet sent. It fires on the byte-sent strobe that empties that tally. The close request is a one-cycle pulse. The framing logic answers it by appending the CRC and the closing flag or sync pattern. Extra writes after the count reaches zero do not wrap it; they set a sticky underflow flag instead.

Top module: `txlen_counter`

## Requirements
- R1: A synchronous active-high `rst` clears `count`, `reload_q`, `underflow`, `term_req` and the internal armed, pending and in-flight state.
- R2: `sw_load` loads `sw_value` into `count` on the next cycle. It takes priority over `msg_start`. Strobes on `fifo_wr` and `byte_sent` in a load cycle are not counted, and the in-flight tally restarts at zero.
- R3: `reload_wr` stores `reload_value`, which appears on `reload_q` one cycle later. `msg_start` without `sw_load` loads `count` from the value `reload_q` shows in that same cycle, so a reload write in that cycle does not affect this load.
- R4: A `fifo_wr` outside a load cycle with `count` nonzero lowers `count` by exactly one on the next cycle.
- R5: A `fifo_wr` outside a load cycle with `count` at zero leaves `count` at zero and sets `underflow`. `underflow` stays set until reset.
- R6: `term_req` is high for exactly one cycle. That cycle follows the `byte_sent` strobe that sends the byte which took `count` to zero, after every earlier counted byte has been sent. A write and a send in the same cycle are both counted.
- R7: `term_req` fires at most once per load. A load of zero arms nothing, so no `term_req` follows it.
- R8: A `byte_sent` strobe while no counted byte is outstanding is ignored. It neither advances nor triggers termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_load | input | 1 | Software load strobe |
| sw_value | input | CNT_W | Value for a software load |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_value | input | CNT_W | Data for the reload register |
| msg_start | input | 1 | Start of a new transmit message (automatic load) |
| fifo_wr | input | 1 | One byte written into the transmit FIFO |
| byte_sent | input | 1 | One byte finished leaving the shifter |
| count | output | CNT_W | Bytes still to be written for this message |
| reload_q | output | CNT_W | Current reload register contents |
| term_req | output | 1 | One-cycle request to close the message |
| underflow | output | 1 | Sticky: a write arrived with the count at zero |

## Verification
If the in-flight tally drifts, `term_req` shows up on the wrong byte-sent strobe: one strobe early or late for a one-off error, or never at all. The sweeps over message length and send lag expose this within one message. A wrong armed or pending bit shows up as a missing pulse, a second pulse, or a pulse after a zero load, on the cycle after the offending strobe. Count errors are visible on `count` one cycle after the write that caused them.

// File: rtl/txlen_pkg.sv
package txlen_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_SW   = 2'd1,
    LD_AUTO = 2'd2
  } load_src_e;
endpackage

// File: rtl/txlen_reload_reg.sv
module txlen_reload_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/txlen_load_sel.sv
module txlen_load_sel
  import txlen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             sw_load,
  input  logic [CNT_W-1:0] sw_value,
  input  logic             msg_start,
  input  logic [CNT_W-1:0] reload_q,
  output logic             load_fire,
  output logic [CNT_W-1:0] load_val,
  output logic             load_nonzero
);
  load_src_e src;

  // software command outranks the automatic message-start load
  function automatic load_src_e pick(input logic sw, input logic auto_ld);
    if (sw)      return LD_SW;
    if (auto_ld) return LD_AUTO;
    return LD_NONE;
  endfunction

  always_comb begin
    src = pick(sw_load, msg_start);
    unique case (src)
      LD_SW:   load_val = sw_value;
      LD_AUTO: load_val = reload_q;
      default: load_val = '0;
    endcase
    load_fire    = (src != LD_NONE);
    load_nonzero = load_fire && (load_val != '0);
  end
endmodule

// File: rtl/txlen_down_counter.sv
module txlen_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_fire,
  input  logic [CNT_W-1:0] load_val,
  input  logic             fifo_wr,
  output logic [CNT_W-1:0] count,
  output logic             wr_counted,
  output logic             hits_zero,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic cnt_zero;
  logic uf_evt;

  function automatic logic [CNT_W-1:0] dec_if(input logic [CNT_W-1:0] v,
                                              input logic en);
    return en ? (v - ONE) : v;
  endfunction

  always_comb begin
    cnt_zero   = (count == '0);
    wr_counted = fifo_wr && !load_fire && !cnt_zero;
    uf_evt     = fifo_wr && !load_fire && cnt_zero;
    hits_zero  = wr_counted && (count == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      underflow <= 1'b0;
    end else begin
      count <= load_fire ? load_val : dec_if(count, wr_counted);
      if (uf_evt) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/txlen_tail_tracker.sv
module txlen_tail_tracker #(
  parameter int INF_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load_fire,
  input  logic load_nonzero,
  input  logic wr_counted,
  input  logic hits_zero,
  input  logic byte_sent,
  output logic sent_counted,
  output logic fire,
  output logic term_req
);
  logic [INF_W-1:0] inflight;
  logic [INF_W-1:0] inflight_n;
  logic             armed;
  logic             final_q;
  logic             final_n;

  function automatic logic [INF_W-1:0] tally_step(input logic [INF_W-1:0] v,
                                                  input logic inc,
                                                  input logic dec);
    logic [INF_W-1:0] r;
    r = v;
    if (inc) r = r + {{(INF_W-1){1'b0}}, 1'b1};
    if (dec) r = r - {{(INF_W-1){1'b0}}, 1'b1};
    return r;
  endfunction

  always_comb begin
    sent_counted = byte_sent && !load_fire && ((inflight != '0) || wr_counted);
    inflight_n   = tally_step(inflight, wr_counted, sent_counted);
    final_n      = final_q || hits_zero;
    fire         = armed && final_n && sent_counted && (inflight_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= '0;
      armed    <= 1'b0;
      final_q  <= 1'b0;
      term_req <= 1'b0;
    end else if (load_fire) begin
      inflight <= '0;
      armed    <= load_nonzero;
      final_q  <= 1'b0;
      term_req <= 1'b0;
    end else begin
      inflight <= inflight_n;
      armed    <= armed && !fire;
      final_q  <= final_n && !fire;
      term_req <= fire;
    end
  end
endmodule

// File: rtl/txlen_counter.sv
module txlen_counter #(
  parameter int CNT_W = 16,
  parameter int INF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_load,
  input  logic [CNT_W-1:0] sw_value,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_value,
  input  logic             msg_start,
  input  logic             fifo_wr,
  input  logic             byte_sent,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload_q,
  output logic             term_req,
  output logic             underflow
);
  logic             load_fire;
  logic [CNT_W-1:0] load_val;
  logic             load_nonzero;
  logic             wr_counted;
  logic             hits_zero;
  logic             sent_counted;
  logic             fire;

  txlen_reload_reg #(.CNT_W(CNT_W)) u_reload (
    .clk(clk), .rst(rst), .wr(reload_wr), .wdata(reload_value), .q(reload_q)
  );

  txlen_load_sel #(.CNT_W(CNT_W)) u_sel (
    .sw_load(sw_load), .sw_value(sw_value), .msg_start(msg_start),
    .reload_q(reload_q), .load_fire(load_fire), .load_val(load_val),
    .load_nonzero(load_nonzero)
  );

  txlen_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_fire(load_fire), .load_val(load_val),
    .fifo_wr(fifo_wr), .count(count), .wr_counted(wr_counted),
    .hits_zero(hits_zero), .underflow(underflow)
  );

  txlen_tail_tracker #(.INF_W(INF_W)) u_tail (
    .clk(clk), .rst(rst), .load_fire(load_fire), .load_nonzero(load_nonzero),
    .wr_counted(wr_counted), .hits_zero(hits_zero), .byte_sent(byte_sent),
    .sent_counted(sent_counted), .fire(fire), .term_req(term_req)
  );
endmodule

// File: rtl/txlen_counter_chk.sv
module txlen_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_load,
  input logic [CNT_W-1:0] sw_value,
  input logic             msg_start,
  input logic             fifo_wr,
  input logic             byte_sent,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_q,
  input logic             term_req,
  input logic             underflow,
  input logic             sent_counted,
  input logic             fire
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0) && !term_req && !underflow && (reload_q == '0));

  a_r2_sw_load: assert property (@(posedge clk) disable iff (rst)
    sw_load |=> count == $past(sw_value));

  a_r3_auto_load: assert property (@(posedge clk) disable iff (rst)
    (msg_start && !sw_load) |=> count == $past(reload_q));

  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && !sw_load && !msg_start && count != '0) |=> count == $past(count) - 1'b1);

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && !sw_load && !msg_start && count == '0) |=> (count == '0) && underflow);

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  a_r6_term_at_zero: assert property (@(posedge clk) disable iff (rst)
    term_req |-> count == '0);

  a_r6_term_after_send: assert property (@(posedge clk) disable iff (rst)
    term_req |-> $past(sent_counted));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    term_req |=> !term_req);

  a_r8_stray_send: assert property (@(posedge clk) disable iff (rst)
    (byte_sent && !sent_counted) |-> !fire);
endmodule

bind txlen_counter txlen_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sw_load(sw_load), .sw_value(sw_value),
  .msg_start(msg_start), .fifo_wr(fifo_wr), .byte_sent(byte_sent),
  .count(count), .reload_q(reload_q), .term_req(term_req),
  .underflow(underflow), .sent_counted(sent_counted), .fire(fire)
);

// File: tb/txlen_counter_test.sv
`timescale 1ns/1ps
module txlen_counter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        sw_load, reload_wr, msg_start, fifo_wr, byte_sent;
  logic [15:0] sw_value, reload_value;
  logic [15:0] count, reload_q;
  logic        term_req, underflow;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  txlen_counter #(.CNT_W(16), .INF_W(5)) uut (
    .clk(clk), .rst(rst), .sw_load(sw_load), .sw_value(sw_value),
    .reload_wr(reload_wr), .reload_value(reload_value), .msg_start(msg_start),
    .fifo_wr(fifo_wr), .byte_sent(byte_sent), .count(count),
    .reload_q(reload_q), .term_req(term_req), .underflow(underflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic snd, input logic swl,
                      input int swv, input logic ms, input logic rw, input int rv);
    @(negedge clk);
    fifo_wr = wr; byte_sent = snd; sw_load = swl; sw_value = 16'(swv);
    msg_start = ms; reload_wr = rw; reload_value = 16'(rv);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    fifo_wr = 0; byte_sent = 0; sw_load = 0; sw_value = 0;
    msg_start = 0; reload_wr = 0; reload_value = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 count", count, 0);
    check("R1 reload_q", reload_q, 0);
    check("R1 term_req", term_req, 0);
    check("R1 underflow", underflow, 0);
    @(negedge clk); rst = 1'b0;

    // R2: software load, priority, load-cycle strobes ignored
    step(0, 0, 0, 0, 0, 1, 9);
    check("R3 reload_q write", reload_q, 9);
    step(0, 0, 1, 5, 1, 0, 0);
    check("R2 sw over auto", count, 5);
    step(1, 1, 1, 4, 0, 0, 0);
    check("R2 write in load cycle ignored", count, 4);
    // R3: same-cycle reload write does not affect this load
    step(0, 0, 0, 0, 1, 1, 7);
    check("R3 auto load uses old reload", count, 9);
    check("R3 reload_q updated", reload_q, 7);

    // R7: zero load arms nothing
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R7 zero load no term", term_req, 0);

    // R8: stray sends ignored mid-message
    step(0, 0, 1, 3, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R8 stray send no term", term_req, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    check("R4 count reached zero", count, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R8 first send no term", term_req, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R8 second send no term", term_req, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R6 third send terms", term_req, 1);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R7 no second term", term_req, 0);

    // R4/R6/R7 sweep: lengths 1..6, send lag 0..3
    for (int n = 1; n <= 6; n++) begin
      for (int lag = 0; lag <= 3; lag++) begin
        int w, s, t, terms;
        logic wr, snd;
        step(0, 0, 0, 0, 0, 1, n);
        step(0, 0, 0, 0, 1, 0, 0);
        check("R3 auto load", count, n);
        w = 0; s = 0; t = 0; terms = 0;
        while (s < n) begin
          wr  = (w < n);
          snd = (t >= lag) && (s < w + int'(wr));
          step(wr, snd, 0, 0, 0, 0, 0);
          w += int'(wr);
          s += int'(snd);
          check("R4 count", count, n - w);
          check("R6 term timing", term_req, (snd && s == n) ? 1 : 0);
          terms += int'(term_req);
          t++;
        end
        idle();
        check("R7 pulse ends", term_req, 0);
        check("R7 one term per message", terms, 1);
      end
    end

    // R5: underflow at zero, sticky
    check("R5 underflow clear before", underflow, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    check("R5 count stays zero", count, 0);
    check("R5 underflow set", underflow, 1);
    step(0, 0, 1, 2, 0, 0, 0);
    check("R5 underflow sticky", underflow, 1);

    // R1: reset clears after activity
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 count after reset", count, 0);
    check("R1 underflow after reset", underflow, 0);
    check("R1 reload after reset", reload_q, 0);
    @(negedge clk); rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule